// File: doc/BRIEF.md
# Wide-to-Narrow Host Bridge with Retry

This block is a target on a 32-bit synchronous host bus. It uses active-low frame, initiator-ready, target-ready and stop handshakes. It turns each host access into one or more cycles on a slow 8-bit or 16-bit legacy peripheral bus. Each peripheral cycle has an address latch pulse, then a memory or I/O read or write strobe of programmable length, then one recovery clock. On reads, the bridge collects the narrow results into one 32-bit word before it completes the host transfer.

The bridge has two completion modes. In blocking mode the host waits until every narrow cycle is done. In deferred mode the first access gets a retry and the peripheral cycles run in the background. Later retries of the same access get retries until the data is ready, and the matching retry then completes. Both buses run on one clock. A width input chooses 8-bit or 16-bit peripheral cycles for each access.

Host protocol: the host drives frame and initiator-ready low together with the address, command, byte enables and write data. It holds them until it sees target-ready or stop low, and releases them on the next clock.

Top module: `wide_narrow_bridge`

## Requirements
- R1: In 16-bit mode, an access with all four byte enables active produces exactly two peripheral cycles, at offsets 0 and 2 in that order.
- R2: In 8-bit mode, an access with all four byte enables active produces exactly four peripheral cycles, at offsets 0, 1, 2 and 3 in ascending order.
- R3: A read completes with target-ready asserted once, after the last peripheral cycle. Byte lane k of the returned word comes from peripheral data bits 7:0 of the 8-bit cycle at offset k. Halfword h comes from all 16 data bits of the 16-bit cycle at offset 2h. Lanes that are not fetched read as zero.
- R4: The 24-bit peripheral address is host address bits 23:2 followed by the 2-bit cycle offset. Host address bits 31:24 are ignored. The address holds steady while a strobe is active.
- R5: Each peripheral cycle is one clock with the latch pulse high, then N clocks with one strobe low, then one clock with the pulse low and every strobe high. N is the strobe-length input, and 0 counts as 1.
- R6: The strobe is chosen from the command: memory read, memory write, I/O read or I/O write. At most one strobe is low at a time.
- R7: In deferred mode, a new access gets stop without target-ready and starts the peripheral cycles. Retries get stop until the cycles finish, and then the matching retry completes with target-ready.
- R8: In deferred mode, an access whose address, command or byte enables differ from the pending one gets stop. It starts no peripheral cycle and does not change the pending result.
- R9: Byte enables are active low, one per lane. Only enabled units get a cycle. In 8-bit mode that is each enabled lane. In 16-bit mode it is each half with at least one enabled lane. An access with no lane enabled runs no cycle and still completes.
- R10: In blocking mode, stop is never asserted and target-ready is held back until all cycles are done. Write data is taken on the accepting clock. An 8-bit cycle carries the lane byte on data bits 7:0 with the upper bits zero, and a 16-bit cycle carries the halfword.
- R11: The width input is sampled when the access is accepted. Changing it later has no effect on that access.
- R12: Target-ready and stop are each low for exactly one clock per response, and never both at once.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Shared clock |
| rstN | input | 1 | Active-low synchronous reset |
| delayEn | input | 1 | 1 selects deferred (retry) mode |
| periphIs16 | input | 1 | 1 selects 16-bit peripheral cycles |
| cfgStrobeClks | input | 4 | Strobe length in clocks (0 counts as 1) |
| hostFrameN | input | 1 | Host frame, active low |
| hostIrdyN | input | 1 | Host initiator ready, active low |
| hostIsIo | input | 1 | 1 = I/O command, 0 = memory |
| hostWrite | input | 1 | 1 = write, 0 = read |
| hostAddr | input | 32 | Host address |
| hostBeN | input | 4 | Byte enables, active low |
| hostWdata | input | 32 | Host write data |
| hostRdata | output | 32 | Assembled read data |
| hostTrdyN | output | 1 | Target ready, active low |
| hostStopN | output | 1 | Stop/retry, active low |
| perAddr | output | 24 | Peripheral address |
| perAle | output | 1 | Address latch pulse |
| perMemRdN | output | 1 | Memory read strobe |
| perMemWrN | output | 1 | Memory write strobe |
| perIoRdN | output | 1 | I/O read strobe |
| perIoWrN | output | 1 | I/O write strobe |
| perWdata | output | 16 | Peripheral write data |
| perRdata | input | 16 | Peripheral read data |

## Verification
The hardest case to reach is a foreign access that arrives while a deferred request is still running its cycles. That access must be refused without starting cycles of its own or touching the gathered data. The stimulus issues one deferred access, then a different access to another address before the first can finish, and then retries the first. It compares the cycle log and the returned word with the first access alone. A second hard case is changing the width select and the write data after acceptance, before completion. The bench changes both on the clock after the handshake is taken, and checks that the cycles follow the values that were present at acceptance.

// File: rtl/wnb_pkg.sv
package wnb_pkg;
  typedef struct packed {
    logic latch;    // capture host request, load lane mask, clear read word
    logic pick;     // take lowest pending unit as current
    logic capture;  // store peripheral read data for current unit
  } wnbCtl_t;

  typedef enum logic [2:0] {
    SEQ_IDLE, SEQ_PICK, SEQ_ALE, SEQ_STROBE, SEQ_RECOVER
  } wnbSeq_t;
endpackage

// File: rtl/wnb_ctrl.sv
module wnb_ctrl import wnb_pkg::*; #(
  parameter int STRB_W = 4
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              hostReq,
  input  logic              delayEn,
  input  logic [STRB_W-1:0] cfgStrobeClks,
  input  logic              reqMatch,
  input  logic              maskEmpty,
  input  logic              reqIsIo,
  input  logic              reqWrite,
  output wnbCtl_t           ctl,
  output logic              hostTrdyN,
  output logic              hostStopN,
  output logic              perAle,
  output logic              perMemRdN,
  output logic              perMemWrN,
  output logic              perIoRdN,
  output logic              perIoWrN
);
  wnbSeq_t seqQ;
  logic [STRB_W-1:0] cntQ;
  logic pendingQ, readyQ, trdyQ, stopQ;
  logic responding, accept, complete, retry, seqDone;

  assign responding = trdyQ | stopQ;
  assign accept     = hostReq & ~responding & ~pendingQ;
  assign complete   = hostReq & ~responding & pendingQ & readyQ & reqMatch;
  assign retry      = hostReq & ~responding & delayEn & ~complete;
  assign seqDone    = (seqQ == SEQ_PICK) & maskEmpty;

  always_comb begin
    ctl.latch   = accept;
    ctl.pick    = (seqQ == SEQ_PICK) & ~maskEmpty;
    ctl.capture = (seqQ == SEQ_STROBE) & (cntQ == '0);
  end

  always_ff @(posedge clk) begin
    if (!rstN) begin
      pendingQ <= 1'b0;
      readyQ   <= 1'b0;
      trdyQ    <= 1'b0;
      stopQ    <= 1'b0;
    end else begin
      trdyQ <= complete;
      stopQ <= retry;
      if (accept)        pendingQ <= 1'b1;
      else if (complete) pendingQ <= 1'b0;
      if (accept || complete) readyQ <= 1'b0;
      else if (seqDone)       readyQ <= 1'b1;
    end
  end

  always_ff @(posedge clk) begin
    if (!rstN) begin
      seqQ <= SEQ_IDLE;
      cntQ <= '0;
    end else begin
      unique case (seqQ)
        SEQ_IDLE:    if (accept) seqQ <= SEQ_PICK;
        SEQ_PICK:    seqQ <= maskEmpty ? SEQ_IDLE : SEQ_ALE;
        SEQ_ALE: begin
          cntQ <= (cfgStrobeClks == '0) ? '0 : cfgStrobeClks - 1'b1;
          seqQ <= SEQ_STROBE;
        end
        SEQ_STROBE: begin
          if (cntQ == '0) seqQ <= SEQ_RECOVER;
          else            cntQ <= cntQ - 1'b1;
        end
        SEQ_RECOVER: seqQ <= SEQ_PICK;
        default:     seqQ <= SEQ_IDLE;
      endcase
    end
  end

  logic strobeOn;
  assign strobeOn  = (seqQ == SEQ_STROBE);
  assign perAle    = (seqQ == SEQ_ALE);
  assign perMemRdN = ~(strobeOn & ~reqIsIo & ~reqWrite);
  assign perMemWrN = ~(strobeOn & ~reqIsIo &  reqWrite);
  assign perIoRdN  = ~(strobeOn &  reqIsIo & ~reqWrite);
  assign perIoWrN  = ~(strobeOn &  reqIsIo &  reqWrite);
  assign hostTrdyN = ~trdyQ;
  assign hostStopN = ~stopQ;

  logic anyStrobe;
  assign anyStrobe = ~(perMemRdN & perMemWrN & perIoRdN & perIoWrN);

  assert_resp_exclusive_R12: assert property (@(posedge clk) disable iff (!rstN)
    hostTrdyN || hostStopN);
  assert_trdy_pulse_R12: assert property (@(posedge clk) disable iff (!rstN)
    !hostTrdyN |=> hostTrdyN);
  assert_stop_pulse_R12: assert property (@(posedge clk) disable iff (!rstN)
    !hostStopN |=> hostStopN);
  assert_no_stop_blocking_R10: assert property (@(posedge clk) disable iff (!rstN)
    !$past(delayEn) |-> hostStopN);
  assert_one_strobe_R6: assert property (@(posedge clk) disable iff (!rstN)
    $onehot0({~perMemRdN, ~perMemWrN, ~perIoRdN, ~perIoWrN}));
  assert_ale_then_strobe_R5: assert property (@(posedge clk) disable iff (!rstN)
    perAle |=> (anyStrobe && !perAle));
  assert_recover_gap_R5: assert property (@(posedge clk) disable iff (!rstN)
    $fell(anyStrobe) |-> !perAle);
  assert_trdy_after_cycles_R3: assert property (@(posedge clk) disable iff (!rstN)
    !hostTrdyN |-> (!anyStrobe && !perAle));
endmodule

// File: rtl/wnb_datapath.sv
module wnb_datapath import wnb_pkg::*; #(
  parameter int HOST_W = 32,
  parameter int PER_W  = 16,
  parameter int ADDR_W = 24,
  localparam int LANES = HOST_W / 8,
  localparam int LB    = $clog2(LANES),
  localparam int WL    = PER_W / 8
) (
  input  logic              clk,
  input  logic              rstN,
  input  wnbCtl_t           ctl,
  input  logic [HOST_W-1:0] hostAddr,
  input  logic              hostIsIo,
  input  logic              hostWrite,
  input  logic [LANES-1:0]  hostBeN,
  input  logic [HOST_W-1:0] hostWdata,
  input  logic              periphIs16,
  input  logic [PER_W-1:0]  perRdata,
  output logic [HOST_W-1:0] hostRdata,
  output logic [ADDR_W-1:0] perAddr,
  output logic [PER_W-1:0]  perWdata,
  output logic              reqMatch,
  output logic              maskEmpty,
  output logic              reqIsIo,
  output logic              reqWrite
);
  logic [ADDR_W-1:0] reqAddr;
  logic [LANES-1:0]  reqBeN, laneMask, wideMask;
  logic [HOST_W-1:0] reqWdata, rdataQ;
  logic              reqWide;
  logic [LB-1:0]     curIdx, pickIdx;

  always_comb begin
    wideMask = '0;
    for (int h = 0; h < LANES / WL; h++)
      wideMask[h] = ~&hostBeN[h*WL +: WL];
  end

  always_comb begin
    pickIdx = '0;
    for (int i = LANES - 1; i >= 0; i--)
      if (laneMask[i]) pickIdx = LB'(i);
  end

  always_ff @(posedge clk) begin
    if (!rstN) begin
      reqAddr  <= '0;
      reqIsIo  <= 1'b0;
      reqWrite <= 1'b0;
      reqBeN   <= '1;
      reqWdata <= '0;
      reqWide  <= 1'b0;
      laneMask <= '0;
      curIdx   <= '0;
      rdataQ   <= '0;
    end else begin
      if (ctl.latch) begin
        reqAddr  <= hostAddr[ADDR_W-1:0];
        reqIsIo  <= hostIsIo;
        reqWrite <= hostWrite;
        reqBeN   <= hostBeN;
        reqWdata <= hostWdata;
        reqWide  <= periphIs16;
        laneMask <= periphIs16 ? wideMask : ~hostBeN;
        rdataQ   <= '0;
      end
      if (ctl.pick) begin
        curIdx           <= pickIdx;
        laneMask[pickIdx] <= 1'b0;
      end
      if (ctl.capture) begin
        if (reqWide) rdataQ[int'(curIdx)*PER_W +: PER_W] <= perRdata;
        else         rdataQ[int'(curIdx)*8 +: 8]         <= perRdata[7:0];
      end
    end
  end

  logic [LB:0] offset;
  assign offset    = reqWide ? (LB+1)'(int'(curIdx) * WL) : {1'b0, curIdx};
  assign perAddr   = {reqAddr[ADDR_W-1:LB], LB'(0)} | ADDR_W'(offset);
  assign perWdata  = reqWide ? reqWdata[int'(curIdx)*PER_W +: PER_W]
                             : PER_W'(reqWdata[int'(curIdx)*8 +: 8]);
  assign hostRdata = rdataQ;
  assign maskEmpty = ~|laneMask;
  assign reqMatch  = (hostAddr[ADDR_W-1:0] == reqAddr) && (hostIsIo == reqIsIo) &&
                     (hostWrite == reqWrite) && (hostBeN == reqBeN);

  assert_pick_live_R9: assert property (@(posedge clk) disable iff (!rstN)
    ctl.pick |-> !maskEmpty);
  assert_pick_clears_R9: assert property (@(posedge clk) disable iff (!rstN)
    (ctl.pick && !ctl.latch) |=> ($countones(laneMask) == $countones($past(laneMask)) - 1));
endmodule

// File: rtl/wide_narrow_bridge.sv
module wide_narrow_bridge import wnb_pkg::*; #(
  parameter int HOST_W = 32,
  parameter int PER_W  = 16,
  parameter int ADDR_W = 24,
  parameter int STRB_W = 4
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              delayEn,
  input  logic              periphIs16,
  input  logic [STRB_W-1:0] cfgStrobeClks,
  input  logic              hostFrameN,
  input  logic              hostIrdyN,
  input  logic              hostIsIo,
  input  logic              hostWrite,
  input  logic [HOST_W-1:0] hostAddr,
  input  logic [HOST_W/8-1:0] hostBeN,
  input  logic [HOST_W-1:0] hostWdata,
  output logic [HOST_W-1:0] hostRdata,
  output logic              hostTrdyN,
  output logic              hostStopN,
  output logic [ADDR_W-1:0] perAddr,
  output logic              perAle,
  output logic              perMemRdN,
  output logic              perMemWrN,
  output logic              perIoRdN,
  output logic              perIoWrN,
  output logic [PER_W-1:0]  perWdata,
  input  logic [PER_W-1:0]  perRdata
);
  wnbCtl_t ctl;
  logic reqMatch, maskEmpty, reqIsIo, reqWrite, hostReq;

  assign hostReq = ~hostFrameN & ~hostIrdyN;

  wnb_ctrl #(.STRB_W(STRB_W)) u_ctrl (
    .clk, .rstN, .hostReq, .delayEn, .cfgStrobeClks, .reqMatch, .maskEmpty,
    .reqIsIo, .reqWrite, .ctl, .hostTrdyN, .hostStopN, .perAle,
    .perMemRdN, .perMemWrN, .perIoRdN, .perIoWrN
  );

  wnb_datapath #(.HOST_W(HOST_W), .PER_W(PER_W), .ADDR_W(ADDR_W)) u_dp (
    .clk, .rstN, .ctl, .hostAddr, .hostIsIo, .hostWrite, .hostBeN, .hostWdata,
    .periphIs16, .perRdata, .hostRdata, .perAddr, .perWdata, .reqMatch,
    .maskEmpty, .reqIsIo, .reqWrite
  );

  logic strobeAny;
  assign strobeAny = ~(perMemRdN & perMemWrN & perIoRdN & perIoWrN);

  assert_addr_hold_R4: assert property (@(posedge clk) disable iff (!rstN)
    (strobeAny && $past(strobeAny)) |-> $stable(perAddr));
endmodule

// File: tb/wide_narrow_bridge_bench.sv
module wide_narrow_bridge_bench;
  logic clk = 1'b0;
  logic rstN = 1'b0;
  logic delayEn = 1'b0, periphIs16 = 1'b0;
  logic [3:0] strobeClks = 4'd3;
  logic hostFrameN = 1'b1, hostIrdyN = 1'b1, hostIsIo = 1'b0, hostWrite = 1'b0;
  logic [31:0] hostAddr = '0, hostWdata = '0;
  logic [3:0] hostBeN = 4'hF;
  logic [31:0] hostRdata;
  logic hostTrdyN, hostStopN, perAle, perMemRdN, perMemWrN, perIoRdN, perIoWrN;
  logic [23:0] perAddr;
  logic [15:0] perWdata, perRdata;

  int checks = 0, fails = 0;

  always #5 clk = ~clk;

  function automatic logic [15:0] perFn(input logic [23:0] a);
    return {a[7:0] ^ 8'hC3, a[15:8] + a[7:0]};
  endfunction

  assign perRdata = perFn(perAddr);

  wide_narrow_bridge u_wide_narrow_bridge (
    .clk, .rstN, .delayEn, .periphIs16, .cfgStrobeClks(strobeClks),
    .hostFrameN, .hostIrdyN, .hostIsIo, .hostWrite, .hostAddr, .hostBeN,
    .hostWdata, .hostRdata, .hostTrdyN, .hostStopN, .perAddr, .perAle,
    .perMemRdN, .perMemWrN, .perIoRdN, .perIoWrN, .perWdata, .perRdata
  );

  // peripheral cycle log
  logic [23:0] mAddr [64];
  logic [15:0] mWdata [64];
  int mKind [64];
  int mLen [64];
  int mCount = 0;

  always @(negedge clk) begin
    if (rstN) begin
      if (perAle) begin
        mAddr[mCount % 64] = perAddr;
        mLen[mCount % 64]  = 0;
        mKind[mCount % 64] = -1;
        mCount++;
      end else if (!(perMemRdN && perMemWrN && perIoRdN && perIoWrN) && mCount > 0) begin
        mLen[(mCount-1) % 64]++;
        mKind[(mCount-1) % 64] = !perMemRdN ? 0 : !perMemWrN ? 1 : !perIoRdN ? 2 : 3;
        mWdata[(mCount-1) % 64] = perWdata;
      end
    end
  end

  task automatic check(input bit ok, input string req, input string what,
                       input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s %s actual=%h expected=%h", req, what, act, exp);
    end
  endtask

  function automatic int nUnits(input logic [3:0] beN, input bit w16);
    int n = 0;
    for (int u = 0; u < (w16 ? 2 : 4); u++)
      if (w16 ? (!beN[2*u] || !beN[2*u+1]) : !beN[u]) n++;
    return n;
  endfunction

  function automatic logic [31:0] expRead(input logic [31:0] addr, input logic [3:0] beN, input bit w16);
    logic [31:0] r = '0;
    logic [15:0] d;
    for (int u = 0; u < (w16 ? 2 : 4); u++) begin
      if (w16 && (!beN[2*u] || !beN[2*u+1])) begin
        d = perFn({addr[23:2], 2'b00} | 24'(2*u));
        r[16*u +: 16] = d;
      end else if (!w16 && !beN[u]) begin
        d = perFn({addr[23:2], 2'b00} | 24'(u));
        r[8*u +: 8] = d[7:0];
      end
    end
    return r;
  endfunction

  // one host handshake; caller is at a negedge
  task automatic hostAccess(input bit io, input bit wr, input logic [31:0] addr,
                            input logic [3:0] beN, input logic [31:0] wd, input bit perturb,
                            output bit gotTrdy, output logic [31:0] rd);
    int waitCyc = 0;
    bit saveW = periphIs16;
    hostFrameN = 1'b0; hostIrdyN = 1'b0; hostIsIo = io; hostWrite = wr;
    hostAddr = addr; hostBeN = beN; hostWdata = wd;
    gotTrdy = 1'b0; rd = '0;
    forever begin
      @(negedge clk);
      waitCyc++;
      if (perturb && waitCyc == 1) begin
        hostWdata = ~wd;
        periphIs16 = ~saveW;
      end
      if (!hostTrdyN || !hostStopN) begin
        check(hostTrdyN || hostStopN, "R12", "trdy and stop together", {hostTrdyN, hostStopN}, 2'b01);
        gotTrdy = !hostTrdyN;
        rd = hostRdata;
        break;
      end
      if (waitCyc > 3000) break;
    end
    hostFrameN = 1'b1; hostIrdyN = 1'b1;
    periphIs16 = saveW;
    @(negedge clk);
    check(hostTrdyN && hostStopN, "R12", "response longer than one clock", {hostTrdyN, hostStopN}, 2'b11);
  endtask

  task automatic runTxn(input bit dly, input bit io, input bit wr, input logic [31:0] addr,
                        input logic [3:0] beN, input logic [31:0] wd, input bit perturb);
    bit w16 = periphIs16;
    int n = 0, base, tries = 0, eLen, idx;
    int eU [4];
    bit gotT;
    logic [31:0] rd, eRd;
    logic [23:0] eA;
    logic [15:0] eW;
    string cntReq;
    eLen = (strobeClks == 0) ? 1 : int'(strobeClks);
    for (int u = 0; u < (w16 ? 2 : 4); u++)
      if (w16 ? (!beN[2*u] || !beN[2*u+1]) : !beN[u]) begin eU[n] = u; n++; end
    eRd = expRead(addr, beN, w16);
    cntReq = (beN != 4'h0) ? "R9" : (w16 ? "R1" : "R2");
    delayEn = dly;
    base = mCount;
    hostAccess(io, wr, addr, beN, wd, perturb, gotT, rd);
    tries = 1;
    if (dly) begin
      check(!gotT, "R7", "first deferred access not retried", 32'(gotT), 0);
      while (!gotT && tries < 300) begin
        repeat (2) @(negedge clk);
        hostAccess(io, wr, addr, beN, wd, 1'b0, gotT, rd);
        tries++;
      end
      check(gotT, "R7", "matching retry never completed", 32'(gotT), 1);
    end else begin
      check(gotT, "R10", "blocking access not completed by trdy", 32'(gotT), 1);
    end
    check(mCount - base == n, cntReq, "peripheral cycle count", 32'(mCount - base), 32'(n));
    for (int i = 0; i < n && i < (mCount - base); i++) begin
      idx = (base + i) % 64;
      eA = {addr[23:2], 2'b00} | (w16 ? 24'(2*eU[i]) : 24'(eU[i]));
      eW = w16 ? wd[16*eU[i] +: 16] : {8'h00, wd[8*eU[i] +: 8]};
      check(mAddr[idx] == eA, "R4", "cycle address/order", 32'(mAddr[idx]), 32'(eA));
      check(mKind[idx] == (io ? 2 : 0) + (wr ? 1 : 0), "R6", "strobe kind",
            32'(mKind[idx]), 32'((io ? 2 : 0) + (wr ? 1 : 0)));
      check(mLen[idx] == eLen, "R5", "strobe length", 32'(mLen[idx]), 32'(eLen));
      if (wr) check(mWdata[idx] == eW, "R10", "write data", 32'(mWdata[idx]), 32'(eW));
    end
    if (!wr) check(rd == eRd, "R3", "assembled read word", rd, eRd);
    repeat (2) @(negedge clk);
  endtask

  initial begin
    repeat (500000) @(posedge clk);
    fails++;
    $display("FAIL watchdog expired");
    $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
    $finish;
  end

  initial begin
    bit gotT;
    logic [31:0] rd;
    int base;
    void'($urandom(32'd20240611));
    repeat (4) @(negedge clk);
    check(hostTrdyN && hostStopN && !perAle && perMemRdN && perMemWrN && perIoRdN && perIoWrN,
          "R12", "reset idle outputs",
          {25'd0, hostTrdyN, hostStopN, perAle, perMemRdN, perMemWrN, perIoRdN, perIoWrN}, 32'h6F);
    rstN = 1'b1;
    repeat (2) @(negedge clk);

    // R1: 16-bit full memory read, N=3
    periphIs16 = 1'b1; strobeClks = 4'd3;
    runTxn(0, 0, 0, 32'h0012_3450, 4'h0, 32'h0, 0);
    // R2 / R5: 8-bit full I/O write with N=0
    periphIs16 = 1'b0; strobeClks = 4'd0;
    runTxn(0, 1, 1, 32'h0000_0304, 4'h0, 32'hA1B2_C3D4, 0);
    // R9: single lane 2 in 8-bit mode
    strobeClks = 4'd2;
    runTxn(0, 0, 0, 32'h0000_8888, 4'b1011, 32'h0, 0);
    // R9: only byte 3 in 16-bit mode -> one cycle at offset 2
    periphIs16 = 1'b1;
    runTxn(0, 1, 0, 32'h0000_4400, 4'b0111, 32'h0, 0);
    // R9: no lanes enabled
    runTxn(0, 0, 1, 32'h0000_1000, 4'hF, 32'h1234_5678, 0);
    // R4: upper host address bits ignored
    periphIs16 = 1'b0; strobeClks = 4'd1;
    runTxn(0, 0, 0, 32'hABFF_FFFC, 4'h0, 32'h0, 0);
    // R10 / R11: width and write data changed after acceptance
    periphIs16 = 1'b1; strobeClks = 4'd4;
    runTxn(0, 0, 1, 32'h0000_2220, 4'h0, 32'hDEAD_BEEF, 1);
    periphIs16 = 1'b0;
    runTxn(0, 1, 0, 32'h0000_0330, 4'h0, 32'h0, 1);
    // R7: deferred 8-bit full read
    strobeClks = 4'd3;
    runTxn(1, 0, 0, 32'h0055_6670, 4'h0, 32'h0, 0);

    // R8: foreign access while a deferred read is pending
    delayEn = 1'b1; periphIs16 = 1'b0; strobeClks = 4'd5;
    base = mCount;
    hostAccess(0, 0, 32'h0000_7700, 4'h0, 32'h0, 0, gotT, rd);
    check(!gotT, "R7", "first deferred access", 32'(gotT), 0);
    hostAccess(1, 0, 32'h0000_9900, 4'h0, 32'h0, 0, gotT, rd);
    check(!gotT, "R8", "foreign access not retried", 32'(gotT), 0);
    for (int t = 0; t < 300 && !gotT; t++) begin
      @(negedge clk);
      hostAccess(0, 0, 32'h0000_7700, 4'h0, 32'h0, 0, gotT, rd);
    end
    check(gotT, "R8", "pending access completed", 32'(gotT), 1);
    check(mCount - base == 4, "R8", "foreign access started cycles", 32'(mCount - base), 4);
    check(rd == expRead(32'h0000_7700, 4'h0, 0), "R8", "pending data disturbed",
          rd, expRead(32'h0000_7700, 4'h0, 0));
    repeat (2) @(negedge clk);
    runTxn(1, 1, 0, 32'h0000_9900, 4'h0, 32'h0, 0);

    // constrained random mix
    for (int it = 0; it < 60; it++) begin
      logic [3:0] be;
      be = ($urandom % 3 == 0) ? 4'($urandom) : 4'h0;
      periphIs16 = 1'($urandom);
      strobeClks = 4'($urandom % 5);
      runTxn(1'($urandom), 1'($urandom), 1'($urandom), $urandom, be, $urandom, 1'($urandom % 4 == 0));
    end

    $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
    $finish;
  end
endmodule